// File: doc/BRIEF.md
# Dual-Port 4x4 Register File

A small buffer store of four words, four bits each, with a write port and a read port that work independently. The write port takes a 2-bit word code, an active-low enable and a 4-bit data word. The read port takes its own 2-bit word code and active-low enable, and presents one whole word on four outputs in true form.

Storage is captured on the rising clock edge while the write enable is low. When the read port selects the word that is being written, the incoming data flows through to the outputs at once, as a transparent latch would. This lets a consumer read any word, including the one being updated, in the same cycle as a producer writes it. With the read enable high the outputs rest at all ones.

Top module: `dual_port_rf`

## Requirements
- R1: The store holds 4 words of 4 bits; a 2-bit code selects word index equal to its binary value (code 0 is the first word, code 3 the last) on both ports.
- R2: With wr_en_ni low at a rising edge of clk_i, wr_data_i is stored in the word at wr_addr_i, and all other words keep their contents.
- R3: With wr_en_ni high, no word changes, whatever wr_addr_i and wr_data_i carry.
- R4: With rd_en_ni low, rd_data_o shows the stored word at rd_addr_i, not inverted, in the same cycle the code is applied.
- R5: With rd_en_ni high, rd_data_o is all ones (4'hF), including during reset.
- R6: A read of one word returns its stored value while a different word is being written in the same cycle.
- R7: With both enables low and rd_addr_i equal to wr_addr_i, rd_data_o equals wr_data_i combinationally and follows it within the cycle, before the clock edge stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes are captured on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_addr_i | input | 2 | Write word code |
| wr_en_ni | input | 1 | Write enable, active low |
| wr_data_i | input | 4 | Write data |
| rd_addr_i | input | 2 | Read word code |
| rd_en_ni | input | 1 | Read enable, active low |
| rd_data_o | output | 4 | Read data, true form; all ones when disabled |

## Verification
Each word is loaded with a distinct pattern and read back, then every 4-bit value is cycled through the words, which separates address decoding faults from data bit faults. Writes with the enable high, with the read port idle, and to a word other than the one read show that storage and the two ports do not disturb each other. A same-address write with the data changed mid-cycle distinguishes a true flow-through path from a read of the old or the registered value.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_WORDS = 4;
  localparam int unsigned RF_WIDTH = 4;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned AW    = 2
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             en_ni,
  output logic [WORDS-1:0] sel_o
);
  always_comb begin
    sel_o = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (!en_ni && (addr_i == AW'(i))) sel_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/rf_word.sv
module rf_word #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned WIDTH = 4,
  parameter int unsigned AW    = 2
) (
  input  logic [WORDS-1:0][WIDTH-1:0] words_i,
  input  logic [AW-1:0]               rd_addr_i,
  input  logic                        rd_en_ni,
  input  logic [AW-1:0]               wr_addr_i,
  input  logic                        wr_en_ni,
  input  logic [WIDTH-1:0]            wr_data_i,
  output logic [WIDTH-1:0]            rd_data_o
);
  logic             fwd;
  logic [WIDTH-1:0] stored;

  assign fwd    = !wr_en_ni && (wr_addr_i == rd_addr_i);
  assign stored = words_i[rd_addr_i];

  // flow-through: same-word write is visible before the edge
  always_comb begin
    if (rd_en_ni) rd_data_o = '1;
    else if (fwd) rd_data_o = wr_data_i;
    else          rd_data_o = stored;
  end
endmodule

// File: rtl/dual_port_rf.sv
module dual_port_rf
  import rf_pkg::*;
#(
  parameter int unsigned WORDS = RF_WORDS,
  parameter int unsigned WIDTH = RF_WIDTH,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic             wr_en_ni,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic             rd_en_ni,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WORDS-1:0]            wr_sel;
  logic [WORDS-1:0][WIDTH-1:0] words;

  rf_wr_decode #(.WORDS(WORDS), .AW(AW)) u_dec (
    .addr_i(wr_addr_i),
    .en_ni (wr_en_ni),
    .sel_o (wr_sel)
  );

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    rf_word #(.WIDTH(WIDTH)) u_word (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_sel[g]),
      .d_i   (wr_data_i),
      .q_o   (words[g])
    );
  end

  rf_rd_port #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_rd (
    .words_i  (words),
    .rd_addr_i(rd_addr_i),
    .rd_en_ni (rd_en_ni),
    .wr_addr_i(wr_addr_i),
    .wr_en_ni (wr_en_ni),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/rf_chk.sv
module rf_chk #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned AW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    wr_addr_i,
  input logic             wr_en_ni,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [AW-1:0]    rd_addr_i,
  input logic             rd_en_ni,
  input logic [WIDTH-1:0] rd_data_o
);
  // R5
  rd_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_ni |-> (rd_data_o == {WIDTH{1'b1}}));

  // R7
  flow_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_ni && !wr_en_ni && (rd_addr_i == wr_addr_i)) |-> (rd_data_o == wr_data_i));

  // R2
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(wr_en_ni) && wr_en_ni && !rd_en_ni &&
     (rd_addr_i == $past(wr_addr_i))) |-> (rd_data_o == $past(wr_data_i)));

  // R3
  hold_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && wr_en_ni && $past(wr_en_ni) && !rd_en_ni && !$past(rd_en_ni) &&
     $stable(rd_addr_i)) |-> $stable(rd_data_o));
endmodule

bind dual_port_rf rf_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_addr_i(wr_addr_i),
  .wr_en_ni (wr_en_ni),
  .wr_data_i(wr_data_i),
  .rd_addr_i(rd_addr_i),
  .rd_en_ni (rd_en_ni),
  .rd_data_o(rd_data_o)
);

// File: tb/tb_dual_port_rf.sv
module tb_dual_port_rf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic       wr_en_ni = 1'b1;
  logic [3:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = '0;
  logic       rd_en_ni = 1'b1;
  logic [3:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  event       chk_ev;
  logic [3:0] model [4];

  always #2.5 clk_i = ~clk_i;

  dual_port_rf dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_addr_i(wr_addr_i), .wr_en_ni(wr_en_ni), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_en_ni(rd_en_ni), .rd_data_o(rd_data_o)
  );

  // monitor: pops expected items and compares against the outputs
  initial forever begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rd_data_o !== e) begin
        n_fail++;
        $display("FAIL %s: rd_data_o=%h expected=%h", t, rd_data_o, e);
      end
    end
  end

  // driver side: push an expectation, let outputs settle, hand to monitor
  task automatic expect_out(input logic [3:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    #0.5;
    ->chk_ev;
    #0.1;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk_i);
    wr_en_ni = 1'b0; wr_addr_i = a; wr_data_i = d; rd_en_ni = 1'b1;
    expect_out(4'hF, "R5 idle during write");
    @(negedge clk_i);
    wr_en_ni = 1'b1;
    model[a] = d;
  endtask

  task automatic do_read(input logic [1:0] a, input string t);
    @(negedge clk_i);
    rd_en_ni = 1'b0; rd_addr_i = a;
    expect_out(model[a], t);
  endtask

  initial begin
    #1.0;
    expect_out(4'hF, "R5 during reset");
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 distinct pattern per word
    do_write(2'd0, 4'h3);
    do_write(2'd1, 4'hA);
    do_write(2'd2, 4'h5);
    do_write(2'd3, 4'hC);
    for (int i = 0; i < 4; i++) do_read(2'(i), "R1 R4 word readback");

    // R6 read word 0 while writing word 2
    @(negedge clk_i);
    rd_en_ni = 1'b0; rd_addr_i = 2'd0;
    wr_en_ni = 1'b0; wr_addr_i = 2'd2; wr_data_i = 4'h6;
    expect_out(model[0], "R6 read other word during write");
    @(negedge clk_i);
    wr_en_ni = 1'b1; model[2] = 4'h6;
    expect_out(model[0], "R6 other word after write");
    do_read(2'd2, "R2 written word");

    // R7 flow-through, data changes mid-cycle
    @(negedge clk_i);
    rd_en_ni = 1'b0; rd_addr_i = 2'd1;
    wr_en_ni = 1'b0; wr_addr_i = 2'd1; wr_data_i = 4'h9;
    expect_out(4'h9, "R7 same-word bypass");
    wr_data_i = 4'h0;
    expect_out(4'h0, "R7 bypass follows data");
    @(negedge clk_i);
    wr_en_ni = 1'b1; model[1] = 4'h0;
    expect_out(4'h0, "R2 stored last data");

    // R3 disabled write changes nothing
    @(negedge clk_i);
    wr_en_ni = 1'b1; wr_addr_i = 2'd3; wr_data_i = 4'hF;
    rd_en_ni = 1'b0; rd_addr_i = 2'd3;
    repeat (3) @(negedge clk_i);
    expect_out(4'hC, "R3 hold with write disabled");

    // R2 all words after the above, then full value sweep
    for (int i = 0; i < 4; i++) do_read(2'(i), "R2 other words unchanged");
    for (int v = 0; v < 16; v++) begin
      do_write(2'(v % 4), 4'(v));
      do_read(2'(v % 4), "R4 value sweep");
    end
    for (int i = 0; i < 4; i++) do_read(2'(i), "R2 final contents");

    @(negedge clk_i);
    rd_en_ni = 1'b1;
    expect_out(4'hF, "R5 read disabled");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule